// File: doc/BRIEF.md
# Cascaded Interrupt Controller

This block joins two eight-input interrupt units, a master and a slave, to serve sixteen request lines. Both units have the same structure. Each latches incoming requests, masks them, resolves fixed priority and tracks which inputs are in service. One output, `int_out`, tells the processor that an interrupt is waiting. The processor answers with a one-cycle `int_ack` pulse. One cycle later the block presents the 8-bit vector with `vec_vld`. In-service state is cleared only by explicit end-of-interrupt commands.

Each unit has a byte-wide configuration port with two addresses, command and data. Writing a command byte with bit 4 set starts initialization. The next three data writes then give the vector base, the cascade word and the mode word, in that order. After that, each data write loads the mask register. On the master, the cascade word marks which inputs carry a slave. On the slave, the cascade word gives the slave's identity. A separate 16-bit trigger register selects edge or level sensing for each line.

Typical setup: master base 0x20 with cascade word 0x04, slave base 0x28 with identity 0x02, mode word 0x01 on both. Then master mask 0xFB and slave mask 0xFF.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset both masks are 0xFF, nothing is pending or in service, every line is edge-sensed and `int_out` is low. Line activity during and after reset raises no interrupt until a mask is opened.
- R2: A command write (`cfg_addr`=0) whose byte has bit 4 set clears that unit's mask to 0x00 and clears its pending and in-service state. The next three data writes (`cfg_addr`=1) are taken as the vector base, the cascade word and the mode word; none of them touches the mask.
- R3: Once the three words are taken, every data write loads the 8-bit mask. A 1 bit blocks that input, and a request held behind a mask is delivered once the bit is cleared.
- R4: The delivered vector is the unit's base plus the input number. Lines 0–7 are master inputs 0–7, and lines 8–15 are slave inputs 0–7.
- R5: Within a unit, input 0 has the highest priority and input 7 the lowest. The slave as a whole competes at the master on the input its cascade bit marks (input 2 in the usual setup).
- R6: An input is not granted while it, or any higher-priority input of the same unit, is in service. A higher-priority input may nest above a lower one.
- R7: The command byte 0x20 clears the highest-priority in-service bit of that unit. A slave interrupt leaves the master's cascade input in service, so it needs this command at both units.
- R8: An edge-sensed line latches a request on a 0→1 change and holds it until it is granted. A level-sensed line requests only while it is high, and it requests again after its end-of-interrupt if it is still high.
- R9: A trigger write with `trig_hi`=0 loads lines 0–7 and with `trig_hi`=1 loads lines 8–15. The bit position is the line number modulo 8, and 1 means level-sensed.
- R10: `vec_vld` pulses exactly one cycle after an `int_ack` that arrives while `int_out` is high. An `int_ack` while `int_out` is low produces no pulse and changes no state.
- R11: A master input whose cascade bit is 1 ignores its own line and follows the slave's request. When it is granted, the slave supplies the vector only if the slave's cascade word equals that input number. Otherwise the master's own base plus input number is delivered and the slave's request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_unit | input | 1 | 0 = master, 1 = slave |
| cfg_addr | input | 1 | 0 = command address, 1 = data address |
| cfg_byte | input | 8 | Configuration write data |
| trig_wr | input | 1 | Trigger register byte write strobe |
| trig_hi | input | 1 | 0 = lines 0–7, 1 = lines 8–15 |
| trig_byte | input | 8 | Trigger bits, 1 = level-sensed |
| irq_lines | input | 16 | Interrupt request lines |
| int_ack | input | 1 | Processor acknowledge pulse |
| int_out | output | 1 | Interrupt waiting for the processor |
| vec_vld | output | 1 | Vector valid, one cycle after a taken acknowledge |
| vec_out | output | 8 | Delivered vector |

## Verification
The bench raises several lines in the same cycle to check that the winner is chosen by index and that slave lines rank as master input 2. A design that ranked the slave by raw line number would let line 9 lose to line 4.

It nests a higher-priority grant above a lower one and then issues end-of-interrupt commands one at a time. Clearing the lowest in-service bit, instead of the highest, would release the wrong line.

A slave interrupt is closed only at the slave before a second slave line is raised. A design that released the cascade input early would deliver the second line too soon.

Level lines are held across their end-of-interrupt, and edge pulses are dropped before acknowledge. The bench also gives the slave a cascade word that does not match, and raises the master's raw input 2. Losing a latched edge, missing a held level, or letting the wrong slave answer each shows up as a wrong `int_out` or vector.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  localparam int UNIT_W  = 8;
  localparam int IDX_W   = $clog2(UNIT_W);
  localparam int VEC_W   = 8;
  localparam int INIT_BIT = 4;
  localparam logic [UNIT_W-1:0] CMD_EOI_NS = 8'h20;

  typedef enum logic [1:0] {
    PH_READY = 2'd0,
    PH_BASE  = 2'd1,
    PH_CASC  = 2'd2,
    PH_MODE  = 2'd3
  } init_ph_e;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  // lowest set index wins
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import cirq_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1,
  parameter int N = UNIT_W,
  parameter int W = $clog2(N),
  parameter int V = VEC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_cmd_i,
  input  logic         wr_dat_i,
  input  logic [N-1:0] wr_byte_i,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] lvl_i,
  input  logic         ack_i,
  output logic         int_o,
  output logic [W-1:0] sel_o,
  output logic [V-1:0] base_o,
  output logic [N-1:0] casc_o
);
  init_ph_e     phase_q, phase_n;
  logic [V-1:0] base_q, base_n;
  logic [N-1:0] casc_q, casc_n;
  logic [N-1:0] mask_q, mask_n;
  logic [N-1:0] irr_q, irr_n;
  logic [N-1:0] isr_q, isr_n;
  logic [N-1:0] prev_q;

  logic [N-1:0] lvl_eff, live, cand, rise, grant_oh, eoi_oh;
  logic         c_any, s_any, grant, is_init, is_eoi;
  logic [W-1:0] c_idx, s_idx;

  // cascade inputs of the master always follow the slave level
  generate
    if (IS_MASTER) begin : g_mst
      assign lvl_eff = lvl_i | casc_q;
    end else begin : g_slv
      assign lvl_eff = lvl_i;
    end
  endgenerate

  assign live = (lvl_eff & line_i) | (~lvl_eff & irr_q);
  assign cand = live & ~mask_q;
  assign rise = line_i & ~prev_q;

  irq_prio_pick #(.N(N), .W(W)) u_pick_req (
    .req_i(cand), .any_o(c_any), .idx_o(c_idx)
  );
  irq_prio_pick #(.N(N), .W(W)) u_pick_isr (
    .req_i(isr_q), .any_o(s_any), .idx_o(s_idx)
  );

  assign int_o    = c_any && (!s_any || (c_idx < s_idx));
  assign grant    = ack_i && int_o;
  assign is_init  = wr_cmd_i && wr_byte_i[INIT_BIT];
  assign is_eoi   = wr_cmd_i && (wr_byte_i == CMD_EOI_NS);
  assign grant_oh = grant ? (N'(1) << c_idx) : '0;
  assign eoi_oh   = (is_eoi && s_any) ? (N'(1) << s_idx) : '0;

  assign sel_o  = c_idx;
  assign base_o = base_q;
  assign casc_o = casc_q;

  always_comb begin
    phase_n = phase_q;
    base_n  = base_q;
    casc_n  = casc_q;
    mask_n  = mask_q;
    irr_n   = ((irr_q & ~grant_oh) | rise) & ~lvl_eff;
    isr_n   = (isr_q & ~eoi_oh) | grant_oh;
    if (is_init) begin
      phase_n = PH_BASE;
      mask_n  = '0;
      irr_n   = '0;
      isr_n   = '0;
    end else if (wr_dat_i) begin
      case (phase_q)
        PH_BASE: begin base_n = V'(wr_byte_i); phase_n = PH_CASC; end
        PH_CASC: begin casc_n = wr_byte_i;     phase_n = PH_MODE; end
        PH_MODE: begin                          phase_n = PH_READY; end
        default: begin mask_n = wr_byte_i; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_READY;
      base_q  <= '0;
      casc_q  <= '0;
      mask_q  <= '1;
      irr_q   <= '0;
      isr_q   <= '0;
      prev_q  <= '0;
    end else begin
      phase_q <= phase_n;
      base_q  <= base_n;
      casc_q  <= casc_n;
      mask_q  <= mask_n;
      irr_q   <= irr_n;
      isr_q   <= isr_n;
      prev_q  <= line_i;
    end
  end

  // R2
  init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_init |=> (isr_q == '0 && mask_q == '0 && phase_q == PH_BASE));
  // R3
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat_i && !is_init && phase_q == PH_READY) |=> mask_q == $past(wr_byte_i));
  // R6
  grant_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> isr_q[$past(c_idx)]);
  // R7
  eoi_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_eoi && s_any && !grant) |=> $countones(isr_q) == $countones($past(isr_q)) - 1);
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import cirq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic                cfg_unit,
  input  logic                cfg_addr,
  input  logic [UNIT_W-1:0]   cfg_byte,
  input  logic                trig_wr,
  input  logic                trig_hi,
  input  logic [UNIT_W-1:0]   trig_byte,
  input  logic [2*UNIT_W-1:0] irq_lines,
  input  logic                int_ack,
  output logic                int_out,
  output logic                vec_vld,
  output logic [VEC_W-1:0]    vec_out
);
  localparam int N     = UNIT_W;
  localparam int W     = IDX_W;
  localparam int LINES = 2 * N;

  logic [LINES-1:0] trig_q, trig_n;
  logic [VEC_W-1:0] vec_q, vec_n;
  logic             vld_q;

  logic         m_int, s_int, s_ack, slave_hit, take;
  logic [W-1:0] m_sel, s_sel;
  logic [VEC_W-1:0] m_base, s_base;
  logic [N-1:0] m_casc, s_casc, m_line;
  logic m_wc, m_wd, s_wc, s_wd;

  assign m_wc = cfg_wr && !cfg_unit && !cfg_addr;
  assign m_wd = cfg_wr && !cfg_unit &&  cfg_addr;
  assign s_wc = cfg_wr &&  cfg_unit && !cfg_addr;
  assign s_wd = cfg_wr &&  cfg_unit &&  cfg_addr;

  always_comb begin
    trig_n = trig_q;
    if (trig_wr) begin
      if (trig_hi) trig_n[LINES-1:N] = trig_byte;
      else         trig_n[N-1:0]     = trig_byte;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      m_line[i] = m_casc[i] ? s_int : irq_lines[i];
    end
  end

  irq_unit #(.IS_MASTER(1'b0), .N(N), .W(W), .V(VEC_W)) u_slave (
    .clk(clk), .rst_n(rst_n), .wr_cmd_i(s_wc), .wr_dat_i(s_wd), .wr_byte_i(cfg_byte),
    .line_i(irq_lines[LINES-1:N]), .lvl_i(trig_q[LINES-1:N]), .ack_i(s_ack),
    .int_o(s_int), .sel_o(s_sel), .base_o(s_base), .casc_o(s_casc)
  );

  irq_unit #(.IS_MASTER(1'b1), .N(N), .W(W), .V(VEC_W)) u_master (
    .clk(clk), .rst_n(rst_n), .wr_cmd_i(m_wc), .wr_dat_i(m_wd), .wr_byte_i(cfg_byte),
    .line_i(m_line), .lvl_i(trig_q[N-1:0]), .ack_i(int_ack),
    .int_o(m_int), .sel_o(m_sel), .base_o(m_base), .casc_o(m_casc)
  );

  assign take      = int_ack && m_int;
  assign slave_hit = m_casc[m_sel] && (s_casc == N'(m_sel));
  assign s_ack     = take && slave_hit;
  assign vec_n     = slave_hit ? (s_base + VEC_W'(s_sel)) : (m_base + VEC_W'(m_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      vec_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      trig_q <= trig_n;
      vld_q  <= take;
      if (take) vec_q <= vec_n;
    end
  end

  assign int_out = m_int;
  assign vec_vld = vld_q;
  assign vec_out = vec_q;

  // R10
  no_spurious_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !int_out) |=> !vec_vld);
  // R10
  vld_follows_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld |-> $past(int_ack));
endmodule

// File: tb/tb_cascade_irq_ctrl.sv
module tb_cascade_irq_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr, cfg_unit, cfg_addr, trig_wr, trig_hi, int_ack;
  logic [7:0] cfg_byte, trig_byte;
  logic [15:0] irq;
  logic int_out, vec_vld;
  logic [7:0] vec_out;

  always #(CLK_P/2) clk = ~clk;

  cascade_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_unit(cfg_unit), .cfg_addr(cfg_addr),
    .cfg_byte(cfg_byte), .trig_wr(trig_wr), .trig_hi(trig_hi), .trig_byte(trig_byte),
    .irq_lines(irq), .int_ack(int_ack), .int_out(int_out), .vec_vld(vec_vld), .vec_out(vec_out)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [7:0] md_mask [2];
  logic [7:0] md_isr  [2];
  logic [7:0] md_irr  [2];
  logic [7:0] md_prev [2];
  logic [7:0] md_base [2];
  logic [7:0] md_casc [2];
  int         md_ph   [2];
  logic [15:0] md_trig;
  logic        md_vld;
  logic [7:0]  md_vec;

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic int unit_pick(input int u, input logic [7:0] ln, input logic [7:0] lv);
    logic [7:0] pend;
    int c, s;
    pend = (lv & ln) | (~lv & md_irr[u]);
    c = lowest(pend & ~md_mask[u]);
    s = lowest(md_isr[u]);
    return (c < 8 && c < s) ? c : 8;
  endfunction

  function automatic void view(output int sp, output int mp,
                               output logic [7:0] ml, output logic [7:0] mlv);
    sp = unit_pick(1, irq[15:8], md_trig[15:8]);
    for (int i = 0; i < 8; i++) ml[i] = md_casc[0][i] ? (sp < 8) : irq[i];
    mlv = md_trig[7:0] | md_casc[0];
    mp = unit_pick(0, ml, mlv);
  endfunction

  task automatic mdl_unit(input int u, input logic [7:0] ln, input logic [7:0] lv, input int g,
                          input logic wc, input logic wd, input logic [7:0] b);
    logic [7:0] goh, eoh;
    int s;
    goh = (g < 8) ? 8'(1 << g) : 8'h00;
    s = lowest(md_isr[u]);
    eoh = (wc && b == 8'h20 && s < 8) ? 8'(1 << s) : 8'h00;
    if (wc && b[4]) begin
      md_ph[u] = 1; md_mask[u] = 8'h00; md_irr[u] = 8'h00; md_isr[u] = 8'h00;
    end else begin
      md_irr[u] = ((md_irr[u] & ~goh) | (ln & ~md_prev[u])) & ~lv;
      md_isr[u] = (md_isr[u] & ~eoh) | goh;
      if (wd) begin
        case (md_ph[u])
          1: begin md_base[u] = b; md_ph[u] = 2; end
          2: begin md_casc[u] = b; md_ph[u] = 3; end
          3: md_ph[u] = 0;
          default: md_mask[u] = b;
        endcase
      end
    end
    md_prev[u] = ln;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int u = 0; u < 2; u++) begin
        md_mask[u] = 8'hFF; md_isr[u] = 0; md_irr[u] = 0; md_prev[u] = 0;
        md_base[u] = 0; md_casc[u] = 0; md_ph[u] = 0;
      end
      md_trig = 0; md_vld = 0; md_vec = 0;
    end else begin
      int sp, mp, sg;
      logic [7:0] ml, mlv;
      logic tk, hit;
      view(sp, mp, ml, mlv);
      tk  = int_ack && (mp < 8);
      hit = tk && md_casc[0][mp] && (md_casc[1] == 8'(mp));
      md_vld = tk;
      if (tk) md_vec = hit ? md_base[1] + 8'(sp) : md_base[0] + 8'(mp);
      sg = hit ? sp : 8;
      mdl_unit(0, ml, mlv, tk ? mp : 8, cfg_wr && !cfg_unit && !cfg_addr,
               cfg_wr && !cfg_unit && cfg_addr, cfg_byte);
      mdl_unit(1, irq[15:8], md_trig[15:8], sg, cfg_wr && cfg_unit && !cfg_addr,
               cfg_wr && cfg_unit && cfg_addr, cfg_byte);
      if (trig_wr) begin
        if (trig_hi) md_trig[15:8] = trig_byte;
        else         md_trig[7:0]  = trig_byte;
      end
    end
  end

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (rst_n && !done) begin
      int sp, mp;
      logic [7:0] ml, mlv;
      view(sp, mp, ml, mlv);
      check("int_out", 8'(int_out), 8'(mp < 8));
      check("vec_vld", 8'(vec_vld), 8'(md_vld));
      if (md_vld) check("vec_out", vec_out, md_vec);
    end
  end

  task automatic cfg(input logic u, input logic a, input logic [7:0] b);
    @(negedge clk);
    cfg_wr = 1; cfg_unit = u; cfg_addr = a; cfg_byte = b;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic init_unit(input logic u, input logic [7:0] base, input logic [7:0] cw);
    cfg(u, 0, 8'h11); cfg(u, 1, base); cfg(u, 1, cw); cfg(u, 1, 8'h01);
  endtask

  task automatic eoi(input logic u); cfg(u, 0, 8'h20); endtask

  task automatic trg(input logic hi, input logic [7:0] b);
    @(negedge clk);
    trig_wr = 1; trig_hi = hi; trig_byte = b;
    @(negedge clk);
    trig_wr = 0;
  endtask

  task automatic ack();
    @(negedge clk); int_ack = 1;
    @(negedge clk); int_ack = 0;
  endtask

  task automatic lines(input logic [15:0] v); @(negedge clk); irq = v; endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  // explicit vector check right after an acknowledge
  task automatic ack_expect(input logic [7:0] exp);
    ack();
    #(CLK_P/4 + 1);
    check("explicit vector", vec_out, exp);
    check("explicit vld", 8'(vec_vld), 8'h01);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_wr = 0; cfg_unit = 0; cfg_addr = 0; cfg_byte = 0;
    trig_wr = 0; trig_hi = 0; trig_byte = 0; irq = 0; int_ack = 0;
    idle(3);
    #(CLK_P/4);
    cur_req = "R1";
    check("int_out in reset", 8'(int_out), 8'h00);
    @(negedge clk); rst_n = 1;

    // R1 / R10: closed masks, acknowledge ignored
    lines(16'hFFFF); idle(3); ack(); idle(2); lines(16'h0000); idle(2);

    cur_req = "R2";
    init_unit(0, 8'h20, 8'h04);
    init_unit(1, 8'h28, 8'h02);
    lines(16'h0040); idle(1);
    ack_expect(8'h26); eoi(0); lines(0); idle(1);
    // partial init keeps mask untouched until words done
    cfg(0, 0, 8'h11); cfg(0, 1, 8'h20); lines(16'h0008); idle(1);
    cfg(0, 1, 8'h04); cfg(0, 1, 8'h01); ack_expect(8'h23); eoi(0); lines(0);

    cur_req = "R3";
    cfg(0, 1, 8'hFB); cfg(1, 1, 8'hFF);
    lines(16'h0020); lines(16'h0000); idle(2);
    cfg(1, 1, 8'h00); idle(1);
    cfg(0, 1, 8'hDB); idle(1);
    ack_expect(8'h25); eoi(0); idle(1);

    cur_req = "R5";
    cfg(0, 1, 8'h00);
    lines(16'h0212); idle(1);
    ack_expect(8'h21); idle(1);
    cur_req = "R4";
    eoi(0); ack_expect(8'h29); eoi(1); eoi(0);
    ack_expect(8'h24); eoi(0); lines(0); idle(1);

    cur_req = "R6";
    lines(16'h0020); ack_expect(8'h25);
    lines(16'h0021); idle(1); ack_expect(8'h20);
    lines(16'h0061); idle(2);

    cur_req = "R7";
    eoi(0); idle(1); eoi(0); ack_expect(8'h26); eoi(0); lines(0); idle(1);
    lines(16'h0400); ack_expect(8'h2A); eoi(1);
    lines(16'h0C00); idle(2); eoi(0); ack_expect(8'h2B); eoi(1); eoi(0); lines(0); idle(1);

    cur_req = "R8";
    lines(16'h0080); lines(16'h0000); idle(2); ack_expect(8'h27); eoi(0);
    trg(0, 8'h08); lines(16'h0008); ack_expect(8'h23); eoi(0); idle(1);
    lines(16'h0000); idle(1); ack(); idle(1);

    cur_req = "R9";
    trg(1, 8'h10); lines(16'h1000); ack_expect(8'h2C); eoi(1); eoi(0); idle(1);
    lines(16'h0000); trg(1, 8'h00); lines(16'h1000); lines(16'h0000); idle(1);
    ack_expect(8'h2C); eoi(1); eoi(0); trg(0, 8'h00);

    cur_req = "R11";
    lines(16'h0004); idle(2); lines(0);
    init_unit(1, 8'h28, 8'h03);
    lines(16'h0200); idle(1); ack_expect(8'h22); eoi(0); idle(2);
    init_unit(1, 8'h28, 8'h02); lines(0);
    lines(16'h0200); lines(0); ack_expect(8'h29); eoi(1); eoi(0); idle(1);

    cur_req = "R10";
    ack(); idle(2);
    cur_req = "R2";
    lines(16'h0002); ack_expect(8'h21);
    init_unit(0, 8'h20, 8'h04); lines(0); lines(16'h0002); ack_expect(8'h21); eoi(0);
    idle(3);
    finish_run();
  end
endmodule